// File: doc/BRIEF.md
# Trap Entry and Return Stack Sequencer

This block performs the hardware portion of switching a processor into a fault or interrupt handler and back out again. When a trap request arrives, it captures the interrupted context: the stack selector, stack pointer, flags word, code selector and instruction pointer. It moves to the kernel stack described by the task-state inputs and writes the captured context onto that stack one 64-bit word at a time. An error code follows as a sixth word when the trap carries one. The block then drops the privilege level to 0 and reads the handler's code selector and entry address from the vector table. Finally it hands the new context to the core with a one-cycle load strobe.

A return command walks the same frame in the opposite direction. If the last entry pushed an error code, that slot is stepped over first. The return reloads instruction pointer, code selector, flags, stack pointer and stack selector, in that order. It then presents them with the same load strobe and raises the privilege level back to 3.

Memory traffic flows through a write port and a read port, each with valid/ready handshakes. The block raises `wr_valid` or `rd_valid` and then holds the address and any write data unchanged until the memory side answers with ready. A transfer completes on the first rising edge where valid and ready are both high. The memory side may keep ready low for any number of cycles, and the sequencer simply stalls. Read data must be valid in the cycle that `rd_ready` is high. The block never drives both ports in the same cycle. Trap, return and load signals are plain pulses without handshakes.

Top module: `trapseq_top`

## Requirements
- R1: After reset, `busy` and `ld_valid` are low, `wr_valid` and `rd_valid` are low, and `priv_lvl` is 3.
- R2: A trap request seen while idle raises `busy` on the next cycle. `busy` stays high until the handler address has been read. `ld_valid` pulses for exactly one cycle, in the first cycle that `busy` is low again.
- R3: With kernel stack top K, the entry writes go out in this order: stack selector at K-8, stack pointer at K-16, flags at K-24, code selector at K-32, instruction pointer at K-40. Each write uses an address 8 below the one before it. Selectors are zero-extended to 64 bits.
- R4: When `trap_has_err` is set at acceptance, a sixth write places `trap_err` at K-48. Otherwise exactly five writes occur.
- R5: While a transfer is waiting for ready, its valid, address and write data stay unchanged, and the next transfer does not start until the current one completes.
- R6: `priv_lvl` is 0 by the time the entry's `ld_valid` pulse appears.
- R7: The vector table entry for vector v sits at `vtab_base + 16*v`. The selector is taken from the low 16 bits of the word at offset 0, and the entry address is the full word at offset 8. On the entry's load strobe, `ld_cs`/`ld_ip` carry these values, `ld_ss` carries `kstk_ss`, `ld_sp` carries the final pushed stack pointer (K-40 or K-48), and `ld_flags` carries the captured flags.
- R8: Trap and return requests that arrive while `busy` is high are ignored. No extra transfers and no extra load strobe result from them.
- R9: A return reads five words at ascending addresses, starting at the entry's final stack pointer plus 8 when that entry pushed an error code. The words are taken as instruction pointer, code selector (low 16 bits), flags, stack pointer and stack selector (low 16 bits). They appear on the `ld_*` outputs with a load strobe, and `priv_lvl` becomes 3 at that point.
- R10: When a trap request and a return request are both high in the same idle cycle, the trap is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request pulse |
| trap_vec | input | VEC_W | Vector number of the trap |
| trap_has_err | input | 1 | Trap carries an error code |
| trap_err | input | XLEN | Error code value |
| ret_req | input | 1 | Return-from-handler request pulse |
| cur_ss | input | SEL_W | Interrupted stack selector |
| cur_sp | input | XLEN | Interrupted stack pointer |
| cur_flags | input | XLEN | Interrupted flags word |
| cur_cs | input | SEL_W | Interrupted code selector |
| cur_ip | input | XLEN | Interrupted instruction pointer |
| kstk_ss | input | SEL_W | Kernel stack selector from task-state storage |
| kstk_sp | input | XLEN | Kernel stack top from task-state storage |
| vtab_base | input | XLEN | Vector table base address |
| busy | output | 1 | Sequence in progress |
| priv_lvl | output | 2 | Current privilege level |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | XLEN | Write byte address |
| wr_data | output | XLEN | Write data |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read accepted, data valid |
| rd_addr | output | XLEN | Read byte address |
| rd_data | input | XLEN | Read data |
| ld_valid | output | 1 | One-cycle strobe: load the presented context |
| ld_ss | output | SEL_W | Stack selector to load |
| ld_sp | output | XLEN | Stack pointer to load |
| ld_flags | output | XLEN | Flags word to load |
| ld_cs | output | SEL_W | Code selector to load |
| ld_ip | output | XLEN | Instruction pointer to load |

## Verification
The hardest case to reach is a request arriving in the middle of a sequence that is stalled by memory back-pressure. A trap or return issued then must leave the frame, the table read and the strobe count untouched. The bench's memory model withholds ready for zero, one or two cycles, varying the delay across the sweep. It also injects a second trap, carrying a different vector, together with a return while the first entry is still pushing. A second stress case is the return after an error-carrying entry, which must start one slot higher. The sweep therefore covers every vector in a 16-entry window, both with and without an error code, and rewrites the stacked frame before each return. This proves that the popped values really come from memory.

// File: rtl/trapseq_pkg.sv
package trapseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_POP
  } seq_st_e;

  localparam int WORD_BYTES = 8;
  localparam int SLOT_W     = 3;
  // push slots, in push order
  localparam logic [SLOT_W-1:0] SLOT_SS    = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_SP    = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_FLAGS = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_CS    = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_IP    = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_ERR   = 3'd5;
  // pop steps, in pop order
  localparam logic [SLOT_W-1:0] POP_IP     = 3'd0;
  localparam logic [SLOT_W-1:0] POP_CS     = 3'd1;
  localparam logic [SLOT_W-1:0] POP_FLAGS  = 3'd2;
  localparam logic [SLOT_W-1:0] POP_SP     = 3'd3;
  localparam logic [SLOT_W-1:0] POP_SS     = 3'd4;

  localparam logic [1:0] PRIV_KERNEL = 2'd0;
  localparam logic [1:0] PRIV_USER   = 2'd3;
endpackage

// File: rtl/trapseq_frame_sel.sv
module trapseq_frame_sel
  import trapseq_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int SEL_W = 16
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [SEL_W-1:0]  sv_ss,
  input  logic [XLEN-1:0]   sv_sp,
  input  logic [XLEN-1:0]   sv_flags,
  input  logic [SEL_W-1:0]  sv_cs,
  input  logic [XLEN-1:0]   sv_ip,
  input  logic [XLEN-1:0]   sv_err,
  output logic [XLEN-1:0]   word
);
  localparam int PAD_W = XLEN - SEL_W;

  always_comb begin
    case (slot)
      SLOT_SS:    word = {{PAD_W{1'b0}}, sv_ss};
      SLOT_SP:    word = sv_sp;
      SLOT_FLAGS: word = sv_flags;
      SLOT_CS:    word = {{PAD_W{1'b0}}, sv_cs};
      SLOT_IP:    word = sv_ip;
      default:    word = sv_err;
    endcase
  end
endmodule

// File: rtl/trapseq_addr_unit.sv
module trapseq_addr_unit
  import trapseq_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int VEC_W = 8
) (
  input  seq_st_e          st,
  input  logic [XLEN-1:0]  sp_work,
  input  logic [XLEN-1:0]  tab_base,
  input  logic [VEC_W-1:0] vec,
  output logic [XLEN-1:0]  wr_addr,
  output logic [XLEN-1:0]  rd_addr
);
  localparam int ENT_SHIFT = 4;
  localparam int PAD_W     = XLEN - VEC_W - ENT_SHIFT;
  localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

  logic [XLEN-1:0] ent_addr;

  assign ent_addr = tab_base + {{PAD_W{1'b0}}, vec, {ENT_SHIFT{1'b0}}};
  assign wr_addr  = sp_work - STEP;

  always_comb begin
    case (st)
      ST_VEC_LO: rd_addr = ent_addr;
      ST_VEC_HI: rd_addr = ent_addr + STEP;
      default:   rd_addr = sp_work;
    endcase
  end
endmodule

// File: rtl/trapseq_fsm.sv
module trapseq_fsm
  import trapseq_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int SEL_W = 16,
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic              trap_has_err,
  input  logic [XLEN-1:0]   trap_err,
  input  logic              ret_req,
  input  logic [SEL_W-1:0]  cur_ss,
  input  logic [XLEN-1:0]   cur_sp,
  input  logic [XLEN-1:0]   cur_flags,
  input  logic [SEL_W-1:0]  cur_cs,
  input  logic [XLEN-1:0]   cur_ip,
  input  logic [SEL_W-1:0]  kstk_ss,
  input  logic [XLEN-1:0]   kstk_sp,
  input  logic              wr_ready,
  input  logic              rd_ready,
  input  logic [XLEN-1:0]   rd_data,
  output seq_st_e           st,
  output logic [SLOT_W-1:0] slot,
  output logic [XLEN-1:0]   sp_work,
  output logic [VEC_W-1:0]  vec_q,
  output logic [SEL_W-1:0]  sv_ss,
  output logic [XLEN-1:0]   sv_sp,
  output logic [XLEN-1:0]   sv_flags,
  output logic [SEL_W-1:0]  sv_cs,
  output logic [XLEN-1:0]   sv_ip,
  output logic [XLEN-1:0]   sv_err,
  output logic              busy,
  output logic [1:0]        priv_lvl,
  output logic              wr_valid,
  output logic              rd_valid,
  output logic              ld_valid,
  output logic [SEL_W-1:0]  ld_ss,
  output logic [XLEN-1:0]   ld_sp,
  output logic [XLEN-1:0]   ld_flags,
  output logic [SEL_W-1:0]  ld_cs,
  output logic [XLEN-1:0]   ld_ip
);
  localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

  logic             err_q;
  logic [SEL_W-1:0] kss_q;
  logic [SEL_W-1:0] sel_q;
  logic             last_push;

  assign last_push = (slot == (err_q ? SLOT_ERR : SLOT_IP));
  assign busy      = (st != ST_IDLE);
  assign wr_valid  = (st == ST_PUSH);
  assign rd_valid  = (st == ST_VEC_LO) || (st == ST_VEC_HI) || (st == ST_POP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      slot     <= '0;
      sp_work  <= '0;
      vec_q    <= '0;
      sv_ss    <= '0;
      sv_sp    <= '0;
      sv_flags <= '0;
      sv_cs    <= '0;
      sv_ip    <= '0;
      sv_err   <= '0;
      err_q    <= 1'b0;
      kss_q    <= '0;
      sel_q    <= '0;
      priv_lvl <= PRIV_USER;
      ld_valid <= 1'b0;
      ld_ss    <= '0;
      ld_sp    <= '0;
      ld_flags <= '0;
      ld_cs    <= '0;
      ld_ip    <= '0;
    end else begin
      ld_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          slot <= '0;
          if (trap_req) begin
            sv_ss    <= cur_ss;
            sv_sp    <= cur_sp;
            sv_flags <= cur_flags;
            sv_cs    <= cur_cs;
            sv_ip    <= cur_ip;
            sv_err   <= trap_err;
            err_q    <= trap_has_err;
            vec_q    <= trap_vec;
            kss_q    <= kstk_ss;
            sp_work  <= kstk_sp;
            st       <= ST_PUSH;
          end else if (ret_req) begin
            sp_work <= err_q ? (sp_work + STEP) : sp_work;
            st      <= ST_POP;
          end
        end
        ST_PUSH: begin
          if (wr_ready) begin
            sp_work <= sp_work - STEP;
            if (last_push) begin
              priv_lvl <= PRIV_KERNEL;
              st       <= ST_VEC_LO;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        ST_VEC_LO: begin
          if (rd_ready) begin
            sel_q <= rd_data[SEL_W-1:0];
            st    <= ST_VEC_HI;
          end
        end
        ST_VEC_HI: begin
          if (rd_ready) begin
            ld_ip    <= rd_data;
            ld_cs    <= sel_q;
            ld_ss    <= kss_q;
            ld_sp    <= sp_work;
            ld_flags <= sv_flags;
            ld_valid <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        ST_POP: begin
          if (rd_ready) begin
            sp_work <= sp_work + STEP;
            case (slot)
              POP_IP:    ld_ip    <= rd_data;
              POP_CS:    ld_cs    <= rd_data[SEL_W-1:0];
              POP_FLAGS: ld_flags <= rd_data;
              POP_SP:    ld_sp    <= rd_data;
              default:   ld_ss    <= rd_data[SEL_W-1:0];
            endcase
            if (slot == POP_SS) begin
              ld_valid <= 1'b1;
              priv_lvl <= PRIV_USER;
              err_q    <= 1'b0;
              st       <= ST_IDLE;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trapseq_top.sv
module trapseq_top
  import trapseq_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int SEL_W = 16,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic             trap_has_err,
  input  logic [XLEN-1:0]  trap_err,
  input  logic             ret_req,
  input  logic [SEL_W-1:0] cur_ss,
  input  logic [XLEN-1:0]  cur_sp,
  input  logic [XLEN-1:0]  cur_flags,
  input  logic [SEL_W-1:0] cur_cs,
  input  logic [XLEN-1:0]  cur_ip,
  input  logic [SEL_W-1:0] kstk_ss,
  input  logic [XLEN-1:0]  kstk_sp,
  input  logic [XLEN-1:0]  vtab_base,
  output logic             busy,
  output logic [1:0]       priv_lvl,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [XLEN-1:0]  wr_addr,
  output logic [XLEN-1:0]  wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [XLEN-1:0]  rd_addr,
  input  logic [XLEN-1:0]  rd_data,
  output logic             ld_valid,
  output logic [SEL_W-1:0] ld_ss,
  output logic [XLEN-1:0]  ld_sp,
  output logic [XLEN-1:0]  ld_flags,
  output logic [SEL_W-1:0] ld_cs,
  output logic [XLEN-1:0]  ld_ip
);
  seq_st_e           st;
  logic [SLOT_W-1:0] slot;
  logic [XLEN-1:0]   sp_work;
  logic [VEC_W-1:0]  vec_q;
  logic [SEL_W-1:0]  sv_ss;
  logic [XLEN-1:0]   sv_sp;
  logic [XLEN-1:0]   sv_flags;
  logic [SEL_W-1:0]  sv_cs;
  logic [XLEN-1:0]   sv_ip;
  logic [XLEN-1:0]   sv_err;

  trapseq_fsm #(.XLEN(XLEN), .SEL_W(SEL_W), .VEC_W(VEC_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .trap_req(trap_req), .trap_vec(trap_vec), .trap_has_err(trap_has_err),
    .trap_err(trap_err), .ret_req(ret_req),
    .cur_ss(cur_ss), .cur_sp(cur_sp), .cur_flags(cur_flags),
    .cur_cs(cur_cs), .cur_ip(cur_ip),
    .kstk_ss(kstk_ss), .kstk_sp(kstk_sp),
    .wr_ready(wr_ready), .rd_ready(rd_ready), .rd_data(rd_data),
    .st(st), .slot(slot), .sp_work(sp_work), .vec_q(vec_q),
    .sv_ss(sv_ss), .sv_sp(sv_sp), .sv_flags(sv_flags),
    .sv_cs(sv_cs), .sv_ip(sv_ip), .sv_err(sv_err),
    .busy(busy), .priv_lvl(priv_lvl),
    .wr_valid(wr_valid), .rd_valid(rd_valid),
    .ld_valid(ld_valid), .ld_ss(ld_ss), .ld_sp(ld_sp),
    .ld_flags(ld_flags), .ld_cs(ld_cs), .ld_ip(ld_ip)
  );

  trapseq_frame_sel #(.XLEN(XLEN), .SEL_W(SEL_W)) u_frame (
    .slot(slot), .sv_ss(sv_ss), .sv_sp(sv_sp), .sv_flags(sv_flags),
    .sv_cs(sv_cs), .sv_ip(sv_ip), .sv_err(sv_err), .word(wr_data)
  );

  trapseq_addr_unit #(.XLEN(XLEN), .VEC_W(VEC_W)) u_addr (
    .st(st), .sp_work(sp_work), .tab_base(vtab_base), .vec(vec_q),
    .wr_addr(wr_addr), .rd_addr(rd_addr)
  );
endmodule

// File: rtl/trapseq_chk.sv
module trapseq_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req,
  input logic            busy,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [XLEN-1:0] wr_addr,
  input logic [XLEN-1:0] wr_data,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [XLEN-1:0] rd_addr,
  input logic            ld_valid,
  input logic [1:0]      priv_lvl
);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trap_req) |=> busy);

  // R2
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !busy);

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R5
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));

  // R3
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) - XLEN'(8))));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !rd_valid));

  // R6
  strobe_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (priv_lvl == 2'd0 || priv_lvl == 2'd3));
endmodule

bind trapseq_top trapseq_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .busy(busy),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .ld_valid(ld_valid), .priv_lvl(priv_lvl)
);

// File: tb/sim_trapseq_top.sv
module sim_trapseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int SEL_W = 16;
  localparam int VEC_W = 8;
  localparam logic [63:0] TAB_BASE = 64'h200;
  localparam logic [15:0] KSS = 16'h0018;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 1'b0, trap_has_err = 1'b0, ret_req = 1'b0;
  logic [VEC_W-1:0] trap_vec = '0;
  logic [63:0] trap_err = '0, cur_sp = '0, cur_flags = '0, cur_ip = '0, kstk_sp = '0;
  logic [15:0] cur_ss = '0, cur_cs = '0, kstk_ss = '0;
  logic busy, wr_valid, rd_valid, ld_valid;
  logic wr_ready = 1'b0, rd_ready = 1'b0;
  logic [1:0] priv_lvl;
  logic [63:0] wr_addr, wr_data, rd_addr, rd_data, ld_sp, ld_flags, ld_ip;
  logic [15:0] ld_ss, ld_cs;

  int nchk = 0, nfail = 0;
  int lat = 0, wait_cnt = 0;
  logic [63:0] mem [0:511];
  logic [63:0] wl_addr [0:7];
  logic [63:0] wl_data [0:7];
  logic [63:0] rl_addr [0:7];
  int wcnt = 0, rcnt = 0, ld_cnt = 0;
  logic [63:0] c_sp, c_flags, c_ip;
  logic [15:0] c_ss, c_cs;
  logic [1:0] c_priv;
  logic c_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  trapseq_top #(.XLEN(XLEN), .SEL_W(SEL_W), .VEC_W(VEC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_vec(trap_vec),
    .trap_has_err(trap_has_err), .trap_err(trap_err), .ret_req(ret_req),
    .cur_ss(cur_ss), .cur_sp(cur_sp), .cur_flags(cur_flags), .cur_cs(cur_cs),
    .cur_ip(cur_ip), .kstk_ss(kstk_ss), .kstk_sp(kstk_sp), .vtab_base(TAB_BASE),
    .busy(busy), .priv_lvl(priv_lvl),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .ld_valid(ld_valid), .ld_ss(ld_ss), .ld_sp(ld_sp), .ld_flags(ld_flags),
    .ld_cs(ld_cs), .ld_ip(ld_ip)
  );

  assign rd_data = mem[rd_addr[11:3]];

  // memory side: log and store accepted transfers, capture load strobes
  always @(posedge clk) begin
    if (wr_valid && wr_ready) begin
      mem[wr_addr[11:3]] <= wr_data;
      if (wcnt < 8) begin wl_addr[wcnt] <= wr_addr; wl_data[wcnt] <= wr_data; end
      wcnt <= wcnt + 1;
    end
    if (rd_valid && rd_ready) begin
      if (rcnt < 8) rl_addr[rcnt] <= rd_addr;
      rcnt <= rcnt + 1;
    end
    if (ld_valid) begin
      ld_cnt <= ld_cnt + 1;
      c_ss <= ld_ss; c_sp <= ld_sp; c_flags <= ld_flags; c_cs <= ld_cs; c_ip <= ld_ip;
      c_priv <= priv_lvl; c_busy <= busy;
    end
  end

  // ready generator with programmable wait
  always @(negedge clk) begin
    if (wr_ready || rd_ready) begin
      wr_ready = 1'b0; rd_ready = 1'b0; wait_cnt = 0;
    end else if (wr_valid && wait_cnt >= lat) wr_ready = 1'b1;
    else if (rd_valid && wait_cnt >= lat) rd_ready = 1'b1;
    else if (wr_valid || rd_valid) wait_cnt = wait_cnt + 1;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_ld(input int base);
    int n = 0;
    while (ld_cnt == base && n < 500) begin @(negedge clk); n++; end
    if (ld_cnt == base) begin
      nfail++; nchk++;
      $display("FAIL R2 load strobe timeout: actual %0d expected %0d", ld_cnt, base + 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    for (int v = 0; v < 16; v++) begin
      mem[(TAB_BASE + v*16) >> 3]     = 64'hDEAD_BEEF_0000_0000 | 64'(16'h10 + v);
      mem[(TAB_BASE + v*16 + 8) >> 3] = 64'hFFFF_8000_0000_0000 + 64'(v*64);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 64'(busy), 0);
    chk("R1", "priv", 64'(priv_lvl), 3);
    chk("R1", "wr_valid", 64'(wr_valid), 0);
    chk("R1", "rd_valid", 64'(rd_valid), 0);
    chk("R1", "ld_valid", 64'(ld_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 16; v++) begin
      for (int e = 0; e < 2; e++) begin
        logic [63:0] k, fin;
        int base, n_w;
        k = 64'hF00 - 64'(v*64);
        n_w = e ? 6 : 5;
        fin = k - 64'(8*n_w);
        lat = (v + e) % 3;
        wcnt = 0; rcnt = 0;
        base = ld_cnt;
        // entry
        trap_req = 1'b1; trap_vec = VEC_W'(v); trap_has_err = e[0];
        trap_err = 64'(v*3 + 1);
        cur_ss = 16'h2B + 16'(v); cur_sp = 64'h7000 + 64'(v*16 + e);
        cur_flags = 64'h200 | 64'(v); cur_cs = 16'h33;
        cur_ip = 64'h4000_0000 + 64'(v*256 + e);
        kstk_ss = KSS; kstk_sp = k;
        ret_req = (v == 2 && e == 0);  // R10 both requests together
        @(negedge clk);
        trap_req = 1'b0; ret_req = 1'b0;
        chk("R2", "busy after accept", 64'(busy), 1);
        if (v % 4 == 1) begin
          // R8 extra requests while busy
          trap_req = 1'b1; trap_vec = VEC_W'(v ^ 1); ret_req = 1'b1;
          @(negedge clk);
          trap_req = 1'b0; ret_req = 1'b0;
        end
        wait_ld(base);
        repeat (4) @(negedge clk);
        chk("R2", "one strobe per entry", 64'(ld_cnt), 64'(base + 1));
        chk("R2", "busy low at strobe", 64'(c_busy), 0);
        chk("R4", "write count", 64'(wcnt), 64'(n_w));
        for (int s = 0; s < 5; s++) chk("R3", "push addr", wl_addr[s], k - 64'(8*(s+1)));
        chk("R3", "pushed ss", wl_data[0], 64'(16'h2B + 16'(v)));
        chk("R3", "pushed sp", wl_data[1], 64'h7000 + 64'(v*16 + e));
        chk("R3", "pushed flags", wl_data[2], 64'h200 | 64'(v));
        chk("R3", "pushed cs", wl_data[3], 64'h33);
        chk("R3", "pushed ip", wl_data[4], 64'h4000_0000 + 64'(v*256 + e));
        if (e) begin
          chk("R4", "err addr", wl_addr[5], k - 64'd48);
          chk("R4", "err data", wl_data[5], 64'(v*3 + 1));
        end
        chk("R6", "priv at entry strobe", 64'(c_priv), 0);
        chk("R7", "table read count", 64'(rcnt), 2);
        chk("R7", "table lo addr", rl_addr[0], TAB_BASE + 64'(v*16));
        chk("R7", "table hi addr", rl_addr[1], TAB_BASE + 64'(v*16 + 8));
        chk("R7", "ld_cs", 64'(c_cs), 64'(16'h10 + v));
        chk("R7", "ld_ip", c_ip, 64'hFFFF_8000_0000_0000 + 64'(v*64));
        chk("R7", "ld_ss", 64'(c_ss), 64'(KSS));
        chk("R7", "ld_sp", c_sp, fin);
        chk("R7", "ld_flags", c_flags, 64'h200 | 64'(v));
        if (v % 4 == 1) chk("R8", "busy settles low", 64'(busy), 0);
        if (v == 2 && e == 0) chk("R10", "trap wins, writes", 64'(wcnt), 5);

        // return: rewrite the frame so pops come from memory
        mem[(k - 40) >> 3] = 64'h5000 + 64'(v);
        mem[(k - 32) >> 3] = 64'hFFFF_0000_0000_0023;
        mem[(k - 24) >> 3] = 64'h202 + 64'(e);
        mem[(k - 16) >> 3] = 64'h6000 + 64'(v*8);
        mem[(k - 8) >> 3]  = 64'hABCD_0000_0000_002B;
        wcnt = 0; rcnt = 0;
        base = ld_cnt;
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        chk("R9", "busy after return accept", 64'(busy), 1);
        wait_ld(base);
        repeat (2) @(negedge clk);
        chk("R9", "pop count", 64'(rcnt), 5);
        chk("R9", "no writes on return", 64'(wcnt), 0);
        for (int s = 0; s < 5; s++) chk("R9", "pop addr", rl_addr[s], k - 64'(40 - 8*s));
        chk("R9", "ld_ip", c_ip, 64'h5000 + 64'(v));
        chk("R9", "ld_cs", 64'(c_cs), 64'h23);
        chk("R9", "ld_flags", c_flags, 64'h202 + 64'(e));
        chk("R9", "ld_sp", c_sp, 64'h6000 + 64'(v*8));
        chk("R9", "ld_ss", 64'(c_ss), 64'h2B);
        chk("R9", "priv restored", 64'(c_priv), 3);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL R2 watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule